// File: doc/BRIEF.md
# Two-Wire Command Slave Front End

This block is the bus-facing front end of a small control device that sits on a two-wire I2C-compatible bus. It samples SCL and SDA with the system clock and filters them. From the filtered lines it recognises START, repeated START and STOP conditions. It then walks through the address byte one bit at a time against its own 7-bit address, and acknowledges the master by pulling SDA low through an open-drain enable.

A write transfer delivers a 16-bit word to the register block behind this front end. The word holds a 4-bit command, a 10-bit data value and two sub-bits. The front end presents the command and the data with a one-cycle commit strobe. A read transfer returns the register block's 10-bit readback value in two bytes.

The front end stops following SCL as soon as one address bit differs, or once a STOP has been seen. It then pays no attention to the bus until the next START arrives. It does not stretch the clock or take part in arbitration.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset, sda_drive_low_o, commit_o, cmd_o and data_o are all 0.
- R2: A STOP during a transfer sends the slave idle at once, and a word that was not complete is never committed. A later START frames a new transfer normally.
- R3: The expected address is {ADDR_HI, addr_sel_i}, MSB first, and is followed by R/W (0 = write, 1 = read). On a full match the slave drives SDA low for the whole ninth clock. On the first bit that differs, the slave gives no ACK and ignores every bit that follows until a new START.
- R4: The all-zero general call address is never acknowledged, even when {ADDR_HI, addr_sel_i} is zero.
- R5: A write word is sent as two bytes. Byte 0 is {cmd[3:0], data[9:6]} and byte 1 is {data[5:0], sub[1:0]}. It is committed on the SCL fall that ends the second byte's ACK clock. At that point commit_o pulses high for one cycle, and cmd_o and data_o change only with that pulse.
- R6: A word whose two sub-bits are not both 0 is acknowledged but not committed.
- R7: After one write address, several words can follow one after another, with or without a repeated START and address between them. Each word is committed in the order it was sent.
- R8: After a read address, the slave drives byte {4'b0000, rdback_i[9:6]} and then byte {rdback_i[5:0], 2'b00}, MSB first. The second byte is sent only if the master ACKs the first byte. A master NACK ends the transfer.
- R9: A STOP in the same SCL high pulse as the START that opened the transfer is ignored, and the transfer goes on.
- R10: A pulse on SCL that lasts less than FILT_LEN system-clock samples has no effect on the transfer.
- R11: Each received write byte is acknowledged in its ninth clock. The slave changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL as seen at the pad |
| sda_i | input | 1 | SDA as seen at the pad (the wired-AND bus level) |
| addr_sel_i | input | 1 | Lowest address bit |
| rdback_i | input | 10 | Register value that is returned on a read |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| commit_o | output | 1 | One-cycle strobe when a write word is accepted |
| cmd_o | output | 4 | Committed command nibble |
| data_o | output | 10 | Committed data value |

## Verification
The bench builds the block with ADDR_HI set to zero and FILT_LEN left at 2. With a zero upper address, driving addr_sel_i low makes the expected address equal to the general call. That is the only way to show that the all-zero check, and not the bit compare, is what rejects it. With the filter at two samples, a single-cycle dip on SCL is exactly the kind of glitch that must be absorbed in the middle of a data bit. The same settings also cover a mismatch on the first address bit (0x41) and on a late one (0x03).

// File: rtl/i2cs_pkg.sv
// Shared widths and the frame state type of the two-wire command slave.
// Assumes a fixed 16-bit write word: command, data, two sub-bits.
package i2cs_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int CMD_W    = 4;
    localparam int DATA_W   = 10;
    localparam int SUB_W    = 2;
    localparam int HI_DATA  = BYTE_W - CMD_W;      // data bits in byte 0
    localparam int LO_DATA  = DATA_W - HI_DATA;    // data bits in byte 1
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int NUM_LINES = 2;                  // index 0 = SCL, 1 = SDA

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } frame_state_t;
endpackage

// File: rtl/i2cs_line_filter.sv
// Synchronises one bus line into the clock domain and removes glitches.
// The output follows the input only after FILT_LEN equal synchronised
// samples in a row. Assumes the line idles high (reset value 1).
module i2cs_line_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                clean_q;

    // Two-flop synchroniser, sample history and filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= (hist_q << 1) | FILT_LEN'(sync_q[1]);
            if (&hist_q) begin
                clean_q <= 1'b1;
            end else if (~|hist_q) begin
                clean_q <= 1'b0;
            end
        end
    end

    assign clean_o = clean_q;
endmodule

// File: rtl/i2cs_bus_events.sv
// Turns the filtered SCL and SDA levels into single-cycle events:
// SCL rise, SCL fall, START (SDA falls, SCL high) and STOP (SDA rises,
// SCL high). Assumes both inputs are already synchronous and clean.
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Remembers the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cs_frame.sv
// Frame sequencer. It checks the address one bit at a time, drives the
// ACKs, collects the two write bytes and commits them, and shifts out the
// readback. Assumes one-cycle events from i2cs_bus_events. The SDA drive
// changes only on an SCL fall.
module i2cs_frame
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_lvl,
    input  logic              addr_lo,
    input  logic [DATA_W-1:0] rdback,
    output logic              drive_low,
    output logic              commit,
    output logic [CMD_W-1:0]  cmd,
    output logic [DATA_W-1:0] data,
    output logic              busy
);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

    frame_state_t        state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-1:0]   rx_q;
    logic [BYTE_W-1:0]   hi_q;
    logic [BYTE_W-1:0]   tx_q;
    logic [ADDR_W-1:0]   exp_q;
    logic                second_q;
    logic                rw_q;
    logic                mack_q;
    logic                fresh_q;   // still inside the START's SCL high pulse
    logic                nz_q;      // a 1 has been seen among the address bits
    logic                drive_q;
    logic                commit_q;
    logic [CMD_W-1:0]    cmd_q;
    logic [DATA_W-1:0]   data_q;
    logic [BYTE_W-1:0]   rd_hi;
    logic [BYTE_W-1:0]   rd_lo;

    assign rd_hi = {{CMD_W{1'b0}}, rdback[DATA_W-1 -: HI_DATA]};
    assign rd_lo = {rdback[LO_DATA-1:0], {SUB_W{1'b0}}};

    // Main sequencer: framing, address compare, ACKs, commit and readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rx_q     <= '0;
            hi_q     <= '0;
            tx_q     <= '0;
            exp_q    <= '0;
            second_q <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            fresh_q  <= 1'b0;
            nz_q     <= 1'b0;
            drive_q  <= 1'b0;
            commit_q <= 1'b0;
            cmd_q    <= '0;
            data_q   <= '0;
        end else begin
            commit_q <= 1'b0;
            if (start_ev) begin
                state_q  <= ST_ADDR;
                cnt_q    <= '0;
                exp_q    <= {ADDR_HI, addr_lo};
                second_q <= 1'b0;
                fresh_q  <= 1'b1;
                nz_q     <= 1'b0;
                drive_q  <= 1'b0;
            end else if (stop_ev && !fresh_q) begin
                state_q <= ST_IDLE;
                drive_q <= 1'b0;
            end else begin
                if (scl_fall) begin
                    fresh_q <= 1'b0;
                end
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q <= LAST_ADDR) begin
                                exp_q <= exp_q << 1;
                                if (sda_lvl) begin
                                    nz_q <= 1'b1;
                                end
                                if (sda_lvl != exp_q[ADDR_W-1]) begin
                                    state_q <= ST_IDLE;
                                end else if (cnt_q == LAST_ADDR && !nz_q && !sda_lvl) begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                rw_q <= sda_lvl;
                            end
                        end else if (scl_fall && cnt_q == FULL_BYTE) begin
                            drive_q <= 1'b1;
                            state_q <= ST_AACK;
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt_q    <= '0;
                            second_q <= 1'b0;
                            if (rw_q) begin
                                tx_q    <= rd_hi;
                                drive_q <= ~rd_hi[BYTE_W-1];
                                state_q <= ST_RBYTE;
                            end else begin
                                drive_q <= 1'b0;
                                state_q <= ST_WBYTE;
                            end
                        end
                    end
                    ST_WBYTE: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == FULL_BYTE) begin
                            drive_q <= 1'b1;
                            state_q <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_WBYTE;
                            if (!second_q) begin
                                hi_q     <= rx_q;
                                second_q <= 1'b1;
                            end else begin
                                second_q <= 1'b0;
                                if (rx_q[SUB_W-1:0] == '0) begin
                                    commit_q <= 1'b1;
                                    cmd_q    <= hi_q[BYTE_W-1 -: CMD_W];
                                    data_q   <= {hi_q[HI_DATA-1:0], rx_q[BYTE_W-1 -: LO_DATA]};
                                end
                            end
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt_q == FULL_BYTE) begin
                                drive_q <= 1'b0;
                                state_q <= ST_RACK;
                            end else begin
                                drive_q <= ~tx_q[BYTE_W-2];
                                tx_q    <= tx_q << 1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack_q && !second_q) begin
                                second_q <= 1'b1;
                                cnt_q    <= '0;
                                tx_q     <= rd_lo;
                                drive_q  <= ~rd_lo[BYTE_W-1];
                                state_q  <= ST_RBYTE;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive_low = drive_q;
    assign commit    = commit_q;
    assign cmd       = cmd_q;
    assign data      = data_q;
    assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/twowire_cmd_slave.sv
// Top of the two-wire command slave. It filters both bus lines, derives
// the bus events and runs the frame sequencer. Assumes the pad logic
// returns the wired-AND bus level on sda_i, and that sda_drive_low_o
// enables an open-drain pull-down.
module twowire_cmd_slave
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI  = 6'b011010,
    parameter int                FILT_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic [DATA_W-1:0] rdback_i,
    output logic              sda_drive_low_o,
    output logic              commit_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic scl_lvl;
    logic sda_lvl;
    logic scl_rise;
    logic scl_fall;
    logic start_ev;
    logic stop_ev;
    logic busy;

    assign raw_lines = {sda_i, scl_i};

    // One synchroniser and glitch filter per bus line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (raw_lines[g]),
                .clean_o (clean_lines[g])
            );
        end
    endgenerate

    assign scl_lvl = clean_lines[0];
    assign sda_lvl = clean_lines[1];

    i2cs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cs_frame #(.ADDR_HI(ADDR_HI)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_lvl   (sda_lvl),
        .addr_lo   (addr_sel_i),
        .rdback    (rdback_i),
        .drive_low (sda_drive_low_o),
        .commit    (commit_o),
        .cmd       (cmd_o),
        .data      (data_o),
        .busy      (busy)
    );
endmodule

// File: rtl/twowire_cmd_slave_chk.sv
// Protocol checker for twowire_cmd_slave. It is attached by bind and
// watches the commit outputs, the SDA drive, the filtered SCL level and
// the busy flag.
module twowire_cmd_slave_chk
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_drive_low_o,
    input logic              commit_o,
    input logic [CMD_W-1:0]  cmd_o,
    input logic [DATA_W-1:0] data_o,
    input logic              scl_lvl,
    input logic              busy
);
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);                                   // R5
    AST_DATA_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> commit_o);                            // R5
    AST_CMD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> commit_o);                             // R5
    AST_COMMIT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !scl_lvl);                                    // R5
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !scl_lvl);                   // R11
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_drive_low_o);                               // R3
endmodule

bind twowire_cmd_slave twowire_cmd_slave_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sda_drive_low_o (sda_drive_low_o),
    .commit_o        (commit_o),
    .cmd_o           (cmd_o),
    .data_o          (data_o),
    .scl_lvl         (scl_lvl),
    .busy            (busy)
);

// File: tb/tb_twowire_cmd_slave.sv
// Scoreboard bench: the write tasks queue the words that should be
// committed, and a monitor compares each commit pulse against the queue.
module tb_twowire_cmd_slave;
    localparam int Q = 20;   // clocks per quarter bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b1;
    logic [9:0] rd_val = 10'h1C6;
    logic       drive_low;
    logic       commit;
    logic [3:0] cmd;
    logic [9:0] data;
    logic       sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    logic [13:0] exp_q[$];
    logic [13:0] mon_e;

    assign sda_line = sda_m & ~drive_low;

    always #5 clk = ~clk;

    twowire_cmd_slave #(.ADDR_HI(6'b000000), .FILT_LEN(2)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .addr_sel_i      (addr_sel),
        .rdback_i        (rd_val),
        .sda_drive_low_o (drive_low),
        .commit_o        (commit),
        .cmd_o           (cmd),
        .data_o          (data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares every commit with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && commit) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R6", "unexpected commit", {cmd, data}, 0);
            end else begin
                mon_e = exp_q.pop_front();
                check({cmd, data} == mon_e, "R5/R7", "committed word", {cmd, data}, mon_e);
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input bit b, input bit glitch);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        if (glitch) begin
            scl_m = 1'b0; @(negedge clk);
            scl_m = 1'b1;
        end
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic wr_byte(input logic [7:0] v, input int glitch_bit, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], i == glitch_bit);
        get_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack, 1'b0);
    endtask

    task automatic send_addr(input logic [6:0] a, input bit rw, input bit exp_ack, input string req);
        bit ack;
        wr_byte({a, rw}, -1, ack);
        check(ack == exp_ack, req, "address ACK", ack, exp_ack);
    endtask

    // Driver: sends one word and queues it when a commit is expected.
    task automatic send_word(input logic [3:0] c, input logic [9:0] d, input logic [1:0] s,
                             input bit exp_ack, input bit exp_commit, input int glitch_bit,
                             input string req);
        bit ack;
        wr_byte({c, d[9:6]}, -1, ack);
        check(ack == exp_ack, req, "byte 0 ACK (R11)", ack, exp_ack);
        if (exp_commit) exp_q.push_back({c, d});
        wr_byte({d[5:0], s}, glitch_bit, ack);
        check(ack == exp_ack, req, "byte 1 ACK (R11)", ack, exp_ack);
    endtask

    task automatic drained(input string req);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, req, "pending commits", exp_q.size(), 0);
    endtask

    task automatic read_word(input string req);
        logic [7:0] b0;
        logic [7:0] b1;
        bus_start();
        send_addr(7'h01, 1'b1, 1'b1, req);
        rd_byte(b0, 1'b1);
        rd_byte(b1, 1'b0);
        check(b0 == {4'b0000, rd_val[9:6]}, req, "readback byte 0", b0, {4'b0000, rd_val[9:6]});
        check(b1 == {rd_val[5:0], 2'b00}, req, "readback byte 1", b1, {rd_val[5:0], 2'b00});
        bus_stop();
    endtask

    initial begin
        logic [7:0] junk;
        bit ack;
        repeat (10) @(negedge clk);
        // R1: reset state
        check(drive_low == 1'b0, "R1", "drive after reset", drive_low, 0);
        check(commit == 1'b0, "R1", "commit after reset", commit, 0);
        check({cmd, data} == 14'h0, "R1", "outputs after reset", {cmd, data}, 0);
        rst_n = 1'b1;
        wait_q();

        // R5: a basic write word
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R3");
        send_word(4'hA, 10'h2B5, 2'b00, 1'b1, 1'b1, -1, "R5");
        bus_stop();
        drained("R5");

        // R8: readback of the register input
        read_word("R8");
        rd_val = 10'h3FF;
        read_word("R8");

        // R7: two words after one address, then a repeated START
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R7");
        send_word(4'h3, 10'h001, 2'b00, 1'b1, 1'b1, -1, "R7");
        send_word(4'hF, 10'h3FE, 2'b00, 1'b1, 1'b1, -1, "R7");
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R7");
        send_word(4'h5, 10'h155, 2'b00, 1'b1, 1'b1, -1, "R7");
        bus_stop();
        drained("R7");

        // R6: nonzero sub-bits are acknowledged but not committed
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R6");
        send_word(4'h7, 10'h0F0, 2'b10, 1'b1, 1'b0, -1, "R6");
        send_word(4'h7, 10'h0F0, 2'b01, 1'b1, 1'b0, -1, "R6");
        bus_stop();
        drained("R6");
        check(data == 10'h155, "R6", "data kept", data, 10'h155);

        // R2: STOP after the first byte aborts the word
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R2");
        wr_byte(8'h9C, -1, ack);
        check(ack, "R2", "byte 0 ACK", ack, 1);
        bus_stop();
        drained("R2");
        check({cmd, data} == {4'h5, 10'h155}, "R2", "outputs kept", {cmd, data}, {4'h5, 10'h155});
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R2");
        send_word(4'h9, 10'h0AA, 2'b00, 1'b1, 1'b1, -1, "R2");
        bus_stop();
        drained("R2");

        // R3: mismatch on the first address bit, then bytes that are ignored
        bus_start();
        send_addr(7'h41, 1'b0, 1'b0, "R3");
        send_word(4'h1, 10'h111, 2'b00, 1'b0, 1'b0, -1, "R3");
        bus_stop();
        // R3: mismatch on a late address bit
        bus_start();
        send_addr(7'h03, 1'b0, 1'b0, "R3");
        send_word(4'h2, 10'h222, 2'b00, 1'b0, 1'b0, -1, "R3");
        bus_stop();
        drained("R3");

        // R4: general call with an all-zero own address
        addr_sel = 1'b0;
        bus_start();
        send_addr(7'h00, 1'b0, 1'b0, "R4");
        send_word(4'h4, 10'h044, 2'b00, 1'b0, 1'b0, -1, "R4");
        bus_stop();
        // R3: the address select input moves the match
        bus_start();
        send_addr(7'h01, 1'b0, 1'b0, "R3");
        bus_stop();
        addr_sel = 1'b1;
        drained("R4");

        // R9: a STOP in the START's own high pulse is ignored
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b0; wait_q();
        send_addr(7'h01, 1'b0, 1'b1, "R9");
        send_word(4'hC, 10'h3A5, 2'b00, 1'b1, 1'b1, -1, "R9");
        bus_stop();
        drained("R9");

        // R10: a one-cycle SCL dip inside a data bit is filtered
        bus_start();
        send_addr(7'h01, 1'b0, 1'b1, "R10");
        send_word(4'h6, 10'h2C3, 2'b00, 1'b1, 1'b1, 4, "R10");
        bus_stop();
        drained("R10");

        // R11: the slave is released once a transfer has ended
        check(drive_low == 1'b0, "R11", "drive after stop", drive_low, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule